// File: doc/BRIEF.md
# Registered Carry-Select Adder/Subtractor

This block adds or subtracts two unsigned operands of a parameterized width and captures the result in a bank of output registers. The datapath is cut into 5-bit sections. Each section works out its sum bits and its carry-out twice, at the same time: once as if its carry-in were 0 and once as if it were 1. The real carry coming up from the section below then picks one of the two results. Two sections make up a 10-bit cluster, and the carry out of a cluster is chosen the same way from its upper section. Because both results are ready early, only the selection muxes lie on the long carry path.

A control input chooses add or subtract on every cycle. In subtract mode the B operand is inverted and the carry into the lowest bit is forced to 1, which forms A + ~B + 1. The final carry-out then means "no borrow", so it is 1 exactly when A ≥ B.

Each result bit and the carry-out go into a register that has a clock enable, an asynchronous clear, an asynchronous load, a synchronous clear and a synchronous load. There is also a synchronous reset. These controls let the block act as an accumulator stage, a preset counter or a plain pipelined adder.

Top module: `csel_addsub_reg`

## Requirements
- R1: With `sub`=0, `ena`=1 and no clear, load or reset active at a rising clock edge, after that edge `sum_q` = (`a`+`b`) mod 2^WIDTH and `cout_q` = the carry out of that sum.
- R2: With `sub`=1 under the same conditions, after the edge `sum_q` = (`a`−`b`) mod 2^WIDTH and `cout_q` = 1 exactly when `a` ≥ `b` as unsigned numbers.
- R3: The operation follows the `sub` value sampled at each edge, so switching `sub` from one cycle to the next gives the correct result on every cycle.
- R4: A carry or borrow crosses every 5-bit section boundary and every 10-bit cluster boundary. For example, an all-ones value plus 1 gives `sum_q`=0 and `cout_q`=1.
- R5: While `ena`=0 (with no reset or asynchronous control), `sum_q` and `cout_q` keep their values whatever `a`, `b` and `sub` do.
- R6: With `ena`=1 and `sclr`=1 at an edge, `sum_q` and `cout_q` become 0. This happens even when `sload` is also 1.
- R7: With `ena`=1, `sload`=1 and `sclr`=0 at an edge, `sum_q` takes `ld_data` and `cout_q` becomes 0.
- R8: Raising `aclr` clears `sum_q` and `cout_q` at once, without a clock edge. `aclr` wins over `aload`.
- R9: Raising `aload` while `aclr`=0 loads `ld_data` into `sum_q` and 0 into `cout_q` at once, without a clock edge. While `aload` stays high, every clock edge loads `ld_data` again.
- R10: With `rst`=1 at an edge, `sum_q` and `cout_q` become 0, whatever `ena` is.
- R11: With `ena`=0, `sclr` and `sload` have no effect at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ena | input | 1 | Clock enable for clear, load and capture |
| aclr | input | 1 | Asynchronous clear, active high |
| aload | input | 1 | Asynchronous load of `ld_data`, active high |
| sclr | input | 1 | Synchronous clear, active high |
| sload | input | 1 | Synchronous load of `ld_data`, active high |
| sub | input | 1 | 0 = add, 1 = subtract |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ld_data | input | WIDTH | Value used by both the synchronous and the asynchronous load |
| sum_q | output | WIDTH | Registered result |
| cout_q | output | 1 | Registered carry-out (no-borrow flag in subtract mode) |

## Verification
If the wrong speculative result is picked in some section, the error shows up only for operands whose carry into that section differs from what was assumed. The bad bits appear in `sum_q` one clock after the edge that captured them, and often `cout_q` is wrong as well. For this reason the stimulus includes carries that run across section and cluster boundaries, subtractions with equal operands and with borrows, and a long random run. If a register control takes the wrong priority, the output shows a value other than zero or `ld_data` right after the edge, or right after the asynchronous pulse. The reference model is checked against the outputs on every cycle, so any of these faults is reported within one cycle of the event that causes it.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Width of one speculative section; a cluster holds two sections.
    localparam int SECT_W  = 5;
    localparam int CLUST_W = 2 * SECT_W;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Result of one section for one assumed carry-in.
    typedef struct packed {
        logic [SECT_W-1:0] sum;
        logic              cout;
    } sect_res_t;

    // Action the output register bank takes on a clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_RST  = 3'd1,
        ACT_CLR  = 3'd2,
        ACT_LOAD = 3'd3,
        ACT_SUM  = 3'd4
    } reg_act_e;

    // Priority of the synchronous controls: reset, then the enable gate,
    // then clear over load over normal capture.
    function automatic reg_act_e pick_act(input logic rst, input logic ena,
                                          input logic sclr, input logic sload);
        if (rst)        return ACT_RST;
        else if (!ena)  return ACT_HOLD;
        else if (sclr)  return ACT_CLR;
        else if (sload) return ACT_LOAD;
        else            return ACT_SUM;
    endfunction

endpackage

// File: rtl/csel_section.sv
module csel_section
    import csel_pkg::*;
(
    input  logic [SECT_W-1:0] a,
    input  logic [SECT_W-1:0] b,
    output sect_res_t         res0,
    output sect_res_t         res1
);

    // Two ripple chains side by side: chain k assumes a carry-in of k.
    for (genvar k = 0; k < 2; k++) begin : g_chain
        logic [SECT_W:0]   cy;
        logic [SECT_W-1:0] s;
        assign cy[0] = (k == 1);
        for (genvar i = 0; i < SECT_W; i++) begin : g_bit
            assign s[i]    = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
        end
    end

    assign res0 = {g_chain[0].s, g_chain[0].cy[SECT_W]};
    assign res1 = {g_chain[1].s, g_chain[1].cy[SECT_W]};

endmodule

// File: rtl/csel_sum_path.sv
module csel_sum_path
    import csel_pkg::*;
#(
    parameter int WIDTH = 20
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  op_e              op,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int NSECT = WIDTH / SECT_W;

    logic [WIDTH-1:0] b_eff;
    logic [NSECT:0]   sel_c;

    // Subtraction: invert B for both chains, force carry 1 into bit 0 only.
    assign b_eff    = (op == OP_SUB) ? ~b : b;
    assign sel_c[0] = (op == OP_SUB);

    // Section j sits in cluster j/2; the select after every section covers
    // both the mid-cluster and the cluster-top selection points.
    for (genvar j = 0; j < NSECT; j++) begin : g_sect
        sect_res_t r0, r1;

        csel_section u_sect (
            .a    (a[j*SECT_W +: SECT_W]),
            .b    (b_eff[j*SECT_W +: SECT_W]),
            .res0 (r0),
            .res1 (r1)
        );

        assign sum[j*SECT_W +: SECT_W] = sel_c[j] ? r1.sum  : r0.sum;
        assign sel_c[j+1]              = sel_c[j] ? r1.cout : r0.cout;
    end

    assign cout = sel_c[NSECT];

endmodule

// File: rtl/csel_out_reg.sv
module csel_out_reg
    import csel_pkg::*;
#(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         aclr,
    input  logic         aload,
    input  reg_act_e     act,
    input  logic [W-1:0] adata,
    input  logic [W-1:0] sdata,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // One flop per bit: asynchronous clear over asynchronous load, then the
    // synchronous action chosen in the package function.
    for (genvar i = 0; i < W; i++) begin : g_ff
        logic q_bit;
        always_ff @(posedge clk or posedge aclr or posedge aload) begin
            if (aclr)
                q_bit <= 1'b0;
            else if (aload)
                q_bit <= adata[i];
            else begin
                unique case (act)
                    ACT_RST, ACT_CLR: q_bit <= 1'b0;
                    ACT_LOAD:         q_bit <= sdata[i];
                    ACT_SUM:          q_bit <= d[i];
                    default:          q_bit <= q_bit;
                endcase
            end
        end
        assign q[i] = q_bit;
    end

endmodule

// File: rtl/csel_addsub_reg.sv
module csel_addsub_reg
    import csel_pkg::*;
#(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ena,
    input  logic             aclr,
    input  logic             aload,
    input  logic             sclr,
    input  logic             sload,
    input  logic             sub,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] ld_data,
    output logic [WIDTH-1:0] sum_q,
    output logic             cout_q
);

    localparam int RW = WIDTH + 1;

    op_e              op;
    reg_act_e         act;
    logic [WIDTH-1:0] sum_c;
    logic             cout_c;
    logic [RW-1:0]    load_val;
    logic [RW-1:0]    res_q;

    assign op       = sub ? OP_SUB : OP_ADD;
    assign act      = pick_act(rst, ena, sclr, sload);
    assign load_val = {1'b0, ld_data};

    csel_sum_path #(.WIDTH(WIDTH)) u_path (
        .a    (a),
        .b    (b),
        .op   (op),
        .sum  (sum_c),
        .cout (cout_c)
    );

    // The carry-out rides in the top bit of the same register bank, so every
    // control treats it like a sum bit loaded with 0.
    csel_out_reg #(.W(RW)) u_regs (
        .clk   (clk),
        .aclr  (aclr),
        .aload (aload),
        .act   (act),
        .adata (load_val),
        .sdata (load_val),
        .d     ({cout_c, sum_c}),
        .q     (res_q)
    );

    assign sum_q  = res_q[WIDTH-1:0];
    assign cout_q = res_q[WIDTH];

endmodule

// File: rtl/csel_chk.sv
module csel_chk #(
    parameter int WIDTH = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             ena,
    input logic             aclr,
    input logic             aload,
    input logic             sclr,
    input logic             sload,
    input logic             sub,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] ld_data,
    input logic [WIDTH-1:0] sum_q,
    input logic             cout_q
);

    // Set when an asynchronous control was seen since the last edge.
    logic           async_hit;
    logic [WIDTH:0] ref_q;
    logic           quiet_q;

    always_ff @(posedge clk or posedge aclr or posedge aload) begin
        if (aclr || aload) async_hit <= 1'b1;
        else               async_hit <= 1'b0;
    end

    // Plain arithmetic reference for the value captured at the next edge.
    always_ff @(posedge clk) begin
        ref_q   <= sub ? ({1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1})
                       : ({1'b0, a} + {1'b0, b});
        quiet_q <= !rst && !aclr && !aload;
    end

    // R1 R2 R3 R4
    sum_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !async_hit && !aclr && !aload && $past(quiet_q)
         && $past(ena && !sclr && !sload && !rst && !aclr && !aload))
        |-> ({cout_q, sum_q} == ref_q));

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !async_hit && !aclr && !aload
         && $past(!ena && !rst && !aclr && !aload))
        |-> ($stable(sum_q) && $stable(cout_q)));

    // R6
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !async_hit && !aclr && !aload
         && $past(ena && sclr && !rst && !aclr && !aload))
        |-> (sum_q == '0 && !cout_q));

    // R7
    sync_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !async_hit && !aclr && !aload
         && $past(ena && sload && !sclr && !rst && !aclr && !aload))
        |-> (sum_q == $past(ld_data) && !cout_q));

    // R8
    async_clear_chk: assert property (@(posedge clk) disable iff (rst)
        aclr |-> (sum_q == '0 && !cout_q));

    // R9
    async_load_chk: assert property (@(posedge clk) disable iff (rst)
        (aload && !aclr) |-> (sum_q == ld_data && !cout_q));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        (!rst && $past(rst) && !async_hit && !aclr && !aload)
        |-> (sum_q == '0 && !cout_q));

endmodule

bind csel_addsub_reg csel_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/csel_addsub_reg_bench.sv
`timescale 1ns/1ps
module csel_addsub_reg_bench;

    localparam int W = 20;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst = 1'b1, ena = 1'b0, aclr = 1'b0, aload = 1'b0;
    logic sclr = 1'b0, sload = 1'b0, sub = 1'b0;
    logic [W-1:0] a = '0, b = '0, ld_data = '0;
    logic [W-1:0] sum_q;
    logic         cout_q;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R10";

    // Behavioural model state.
    logic [W-1:0] m_sum  = '0;
    logic         m_cout = 1'b0;

    always #5 clk = ~clk;

    csel_addsub_reg #(.WIDTH(W)) u_csel_addsub_reg (
        .clk(clk), .rst(rst), .ena(ena), .aclr(aclr), .aload(aload),
        .sclr(sclr), .sload(sload), .sub(sub), .a(a), .b(b),
        .ld_data(ld_data), .sum_q(sum_q), .cout_q(cout_q)
    );

    always @(posedge clk or posedge aclr or posedge aload) begin
        if (aclr) begin
            m_sum = '0; m_cout = 1'b0;
        end else if (aload) begin
            m_sum = ld_data; m_cout = 1'b0;
        end else if (rst) begin
            m_sum = '0; m_cout = 1'b0;
        end else if (ena) begin
            if (sclr) begin
                m_sum = '0; m_cout = 1'b0;
            end else if (sload) begin
                m_sum = ld_data; m_cout = 1'b0;
            end else if (sub) begin
                m_sum = a - b; m_cout = (a >= b);
            end else begin
                {m_cout, m_sum} = {1'b0, a} + {1'b0, b};
            end
        end
    end

    task automatic check(input string tag);
        n_checks++;
        if (sum_q !== m_sum || cout_q !== m_cout) begin
            n_errors++;
            $display("FAIL %s: sum_q=%h cout_q=%b expected sum=%h cout=%b",
                     tag, sum_q, cout_q, m_sum, m_cout);
        end
    endtask

    // Every cycle the outputs are compared with the model.
    always @(negedge clk) check(cur_req);

    task automatic cyc(input logic [W-1:0] ta, input logic [W-1:0] tb,
                       input logic tsub, input string tag);
        cur_req = tag; a = ta; b = tb; sub = tsub;
        @(posedge clk); @(negedge clk); #1;
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1; rst = 1'b0; ena = 1'b1;

        // R1 and R4: directed adds across section and cluster edges
        cyc(20'd0, 20'd0, 1'b0, "R1");
        cyc(20'd12345, 20'd54321, 1'b0, "R1");
        cyc(20'h0001F, 20'h00001, 1'b0, "R4");
        cyc(20'h003FF, 20'h00001, 1'b0, "R4");
        cyc(ONES, 20'h00001, 1'b0, "R4");
        cyc(ONES, ONES, 1'b0, "R4");
        for (int i = 0; i < 40; i++)
            cyc(W'($urandom), W'($urandom), 1'b0, "R1");

        // R2: subtraction and the no-borrow flag
        cyc(20'd5, 20'd3, 1'b1, "R2");
        cyc(20'd3, 20'd5, 1'b1, "R2");
        cyc(20'd777, 20'd777, 1'b1, "R2");
        cyc(20'd0, 20'd1, 1'b1, "R4");
        cyc(20'h00400, 20'h00001, 1'b1, "R4");
        for (int i = 0; i < 40; i++)
            cyc(W'($urandom), W'($urandom), 1'b1, "R2");

        // R3: operation switched on every cycle
        for (int i = 0; i < 30; i++)
            cyc(W'($urandom), W'($urandom), 1'(i % 2), "R3");

        // R5: enable low, inputs keep changing
        ena = 1'b0;
        for (int i = 0; i < 5; i++)
            cyc(W'($urandom), W'($urandom), 1'(i % 2), "R5");

        // R11: synchronous controls ignored while disabled
        ld_data = 20'hABCDE; sclr = 1'b1;
        cyc(20'd1, 20'd1, 1'b0, "R11");
        sclr = 1'b0; sload = 1'b1;
        cyc(20'd1, 20'd1, 1'b0, "R11");
        sload = 1'b0; ena = 1'b1;

        // R7: synchronous load
        cyc(ONES, 20'd1, 1'b0, "R1");
        ld_data = 20'h5A5A5; sload = 1'b1;
        cyc(20'd9, 20'd9, 1'b0, "R7");
        sload = 1'b0;
        cyc(20'd100, 20'd1, 1'b0, "R1");

        // R6: synchronous clear, also over a simultaneous load
        sclr = 1'b1; sload = 1'b1;
        cyc(20'd7, 20'd7, 1'b0, "R6");
        sload = 1'b0;
        cyc(ONES, 20'd1, 1'b0, "R6");
        sclr = 1'b0;

        // R8: asynchronous clear, no clock edge
        cyc(20'h12345, 20'h11111, 1'b0, "R1");
        cur_req = "R8";
        #1 aclr = 1'b1; #1 check("R8"); aclr = 1'b0;
        @(negedge clk); #1;

        // R9: asynchronous load, no clock edge
        ld_data = 20'h0F0F0;
        cur_req = "R9";
        #1 aload = 1'b1; #1 check("R9"); aload = 1'b0;
        @(negedge clk); #1;

        // R9: held asynchronous load reloads at each edge
        ld_data = 20'h33333; aload = 1'b1;
        cyc(20'd1, 20'd2, 1'b0, "R9");
        cyc(20'd3, 20'd4, 1'b0, "R9");
        aload = 1'b0;
        cyc(20'd3, 20'd4, 1'b0, "R1");

        // R8: clear wins over a simultaneous load
        ld_data = 20'hFFFF0; cur_req = "R8";
        #1 aload = 1'b1; aclr = 1'b1; #1 check("R8");
        aclr = 1'b0; aload = 1'b0;
        @(negedge clk); #1;

        // R10: reset with enable low
        cyc(20'd50, 20'd60, 1'b0, "R1");
        ena = 1'b0; rst = 1'b1;
        cyc(20'd50, 20'd60, 1'b0, "R10");
        rst = 1'b0; ena = 1'b1;
        cyc(20'd8, 20'd9, 1'b1, "R2");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule